// File: doc/BRIEF.md
# Register-Mapped Bus Command Channel

This block is a software command channel that sits in front of a serial power-management bus master. Software talks to it through a small word-addressed register window. For a write it first loads a data register and then writes a packed command word. For a read it writes only the command word. The channel turns each accepted command into one request that carries the command class, direction, slave ID, byte count and register address. It offers that request to a downstream master over a valid/ready handshake.

Writes need no acknowledge: the channel is idle again as soon as the downstream side takes the request. Reads take two more steps. The channel waits for the response, keeps only the requested low bytes, and then parks in a hold state. In that state the read data stays frozen until software writes 1 to a valid-clear register. A status register shows the state-machine code and a sticky error bit. The error bit records commands that were rejected.

Register window (byte offsets, word aligned): command at 0x00, write data at 0x04, read data at 0x08 (read only), valid-clear at 0x0C, status at 0x10. A read from any other offset returns zero.

Top module: `cmd_chan`

## Requirements
- R1: A command word carries its fields at fixed positions: class in bits 31:30, write flag in bit 29, slave ID in bits 27:24, byte count minus one in bits 17:16, and address in bits 15:0. When the command is accepted, these fields appear unchanged on req_class, req_write, req_sid, req_len and req_addr.
- R2: Classes 0 (register-zero write), 1 (short register access) and 3 (extended long access) are accepted. A command with class 2 is rejected: it raises no request, the channel stays idle, and the sticky error bit is set.
- R3: Reading offset 0x10 returns the state code in bits 3:1 and the sticky error flag in bit 0; all other bits read zero. The codes are 0 (idle), 1 (request offered), 2 (waiting for read response) and 6 (read data valid, waiting for clear). No other code ever appears.
- R4: While req_valid is high and req_ready is low, req_valid stays high and every request field, write data included, holds its value.
- R5: For a write command, req_wdata equals the write-data register. The cycle after the handshake the channel is idle (code 0) with no acknowledge step.
- R6: For a read command, the channel moves to code 2 after the handshake. The first rsp_valid then captures rsp_data into the read-data register, keeping the low (count+1) bytes and zeroing the rest, and the channel moves to code 6.
- R7: In code 6 the channel and the read-data register stay unchanged until software writes a value with bit 0 set to offset 0x0C. That write returns the channel to idle.
- R8: A write to offset 0x0C has no effect outside code 6, and a write with bit 0 clear has no effect in any state.
- R9: A command written while the channel is not idle is ignored: the pending request is unchanged. It also sets the sticky error bit, which stays set until reset.
- R10: A write to the write-data register while the channel is not idle is ignored.
- R11: While rst is high, at the next clock edge the channel goes idle, clears the error bit and both data registers, and drops req_valid.
- R12: rsp_valid has no effect outside code 2: the read-data register and the state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | output | 1 | Downstream request offered |
| req_ready | input | 1 | Downstream master takes the request |
| req_class | output | 2 | Command class |
| req_write | output | 1 | 1 for write, 0 for read |
| req_sid | output | 4 | Slave ID |
| req_len | output | 2 | Byte count minus one |
| req_addr | output | 16 | Slave register address |
| req_wdata | output | 32 | Write data, low bytes significant |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | 32 | Read response data |

## Verification
The bench builds the block with its default 5-bit register offset. Every one of the four class encodings is combined with both directions and all four byte counts. This covers the rejected class, every byte-mask width on the read path, and the write path with no acknowledge. Inside that sweep it also tries four disturbances in the states where they should be ignored: stray commands, write-data updates, valid-clear writes and responses. It checks that each changes nothing visible at the ports.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;

    localparam int DATA_W  = 32;
    localparam int SID_W   = 4;
    localparam int LEN_W   = 2;
    localparam int CLS_W   = 2;
    localparam int RADDR_W = 16;
    localparam int CODE_W  = 3;
    localparam int NBYTES  = DATA_W / 8;

    // word index of each register in the window
    localparam int IDX_CMD   = 0;
    localparam int IDX_WDATA = 1;
    localparam int IDX_RDATA = 2;
    localparam int IDX_VCLR  = 3;
    localparam int IDX_STAT  = 4;
    localparam int NREG      = 5;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_RESP = 3'd2,
        ST_HOLD = 3'd6
    } state_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_REG0 = 2'd0,
        CLS_REG  = 2'd1,
        CLS_RSVD = 2'd2,
        CLS_EXTL = 2'd3
    } cls_e;

    typedef struct packed {
        cls_e               cls;
        logic               wr;
        logic [SID_W-1:0]   sid;
        logic [LEN_W-1:0]   len;
        logic [RADDR_W-1:0] addr;
    } req_t;

    function automatic req_t unpack_cmd(input logic [DATA_W-1:0] w);
        req_t r;
        r.cls  = cls_e'(w[31:30]);
        r.wr   = w[29];
        r.sid  = w[27:24];
        r.len  = w[17:16];
        r.addr = w[15:0];
        return r;
    endfunction

    function automatic logic cls_ok(input cls_e c);
        return c != CLS_RSVD;
    endfunction

    function automatic logic [DATA_W-1:0] keep_bytes(input logic [DATA_W-1:0] d,
                                                     input logic [LEN_W-1:0]  len);
        logic [DATA_W-1:0] o;
        o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (b <= int'(len)) o[8*b +: 8] = d[8*b +: 8];
        end
        return o;
    endfunction

endpackage

// File: rtl/cmd_chan_regdec.sv
module cmd_chan_regdec
    import cmd_chan_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] rdata_q,
    input  logic [DATA_W-1:0] status,
    output logic              hit_cmd,
    output logic              hit_wdata,
    output logic              hit_vclr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [NREG-1:0] sel;
    logic [NREG-1:0] wsel;

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i]  = (reg_addr == AW'(i * 4));
        assign wsel[i] = reg_wr && sel[i];
    end

    assign hit_cmd   = wsel[IDX_CMD];
    assign hit_wdata = wsel[IDX_WDATA];
    assign hit_vclr  = wsel[IDX_VCLR];

    always_comb begin
        reg_rdata = '0;
        if (sel[IDX_WDATA]) reg_rdata = wdata_q;
        if (sel[IDX_RDATA]) reg_rdata = rdata_q;
        if (sel[IDX_STAT])  reg_rdata = status;
    end
endmodule

// File: rtl/cmd_chan_fsm.sv
module cmd_chan_fsm
    import cmd_chan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit_cmd,
    input  req_t   cmd_in,
    input  logic   clr_req,
    input  logic   req_ready,
    input  logic   rsp_valid,
    output state_e st,
    output logic   err_q,
    output req_t   req_q,
    output logic   req_valid,
    output logic   capture
);
    logic reject;

    assign reject    = hit_cmd && ((st != ST_IDLE) || !cls_ok(cmd_in.cls));
    assign req_valid = (st == ST_SEND);
    assign capture   = (st == ST_RESP) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            err_q <= 1'b0;
            req_q <= '0;
        end else begin
            if (reject) err_q <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (hit_cmd && cls_ok(cmd_in.cls)) begin
                        req_q <= cmd_in;
                        st    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (req_ready) st <= req_q.wr ? ST_IDLE : ST_RESP;
                end
                ST_RESP: begin
                    if (rsp_valid) st <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (clr_req) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_chan_data.sv
module cmd_chan_data
    import cmd_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_wdata,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (ld_wdata) wdata_q <= wdata_in;
            if (capture)  rdata_q <= keep_bytes(rsp_data, len);
        end
    end
endmodule

// File: rtl/cmd_chan.sv
module cmd_chan
    import cmd_chan_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_class,
    output logic              req_write,
    output logic [3:0]        req_sid,
    output logic [1:0]        req_len,
    output logic [15:0]       req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_data
);
    localparam int STAT_PAD = DATA_W - CODE_W - 1;

    logic              hit_cmd, hit_wdata, hit_vclr;
    logic              capture, err_q;
    state_e            st;
    logic [CODE_W-1:0] st_code;
    req_t              cmd_in, req_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, status;

    assign cmd_in  = unpack_cmd(reg_wdata);
    assign st_code = st;
    assign status  = {{STAT_PAD{1'b0}}, st_code, err_q};

    cmd_chan_regdec #(.AW(REG_AW)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q),
        .status    (status),
        .hit_cmd   (hit_cmd),
        .hit_wdata (hit_wdata),
        .hit_vclr  (hit_vclr),
        .reg_rdata (reg_rdata)
    );

    cmd_chan_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit_cmd   (hit_cmd),
        .cmd_in    (cmd_in),
        .clr_req   (hit_vclr && reg_wdata[0]),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .st        (st),
        .err_q     (err_q),
        .req_q     (req_q),
        .req_valid (req_valid),
        .capture   (capture)
    );

    cmd_chan_data u_data (
        .clk      (clk),
        .rst      (rst),
        .ld_wdata (hit_wdata && (st == ST_IDLE)),
        .wdata_in (reg_wdata),
        .capture  (capture),
        .rsp_data (rsp_data),
        .len      (req_q.len),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata_q)
    );

    assign req_class = req_q.cls;
    assign req_write = req_q.wr;
    assign req_sid   = req_q.sid;
    assign req_len   = req_q.len;
    assign req_addr  = req_q.addr;
    assign req_wdata = wdata_q;
endmodule

// File: rtl/cmd_chan_chk.sv
module cmd_chan_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [2:0]    st_code,
    input logic          err_q,
    input logic [31:0]   rdata_q,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [56:0]   req_bits
);
    logic clear_wr;
    assign clear_wr = reg_wr && (reg_addr == AW'(12)) && reg_wdata[0];

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_bits)));

    assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
        (st_code == 3'd0 || st_code == 3'd1 || st_code == 3'd2 || st_code == 3'd6));

    assert_write_no_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (st_code == 3'd0));

    assert_hold_until_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (st_code == 3'd6 && !clear_wr) |=> (st_code == 3'd6 && $stable(rdata_q)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !$fell(err_q));

    assert_rsp_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (st_code != 3'd2) |=> $stable(rdata_q));
endmodule

bind cmd_chan cmd_chan_chk #(.AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .st_code   (st_code),
    .err_q     (err_q),
    .rdata_q   (rdata_q),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_bits  ({req_class, req_write, req_sid, req_len, req_addr, req_wdata})
);

// File: tb/cmd_chan_bench.sv
module cmd_chan_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [1:0]  req_class, req_len;
    logic [3:0]  req_sid;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic exp_err = 1'b0;

    localparam logic [4:0] A_CMD = 5'h00, A_WD = 5'h04, A_RD = 5'h08,
                           A_CLR = 5'h0C, A_ST = 5'h10;

    always #10 clk = ~clk;

    cmd_chan u_cmd_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_class(req_class), .req_write(req_write),
        .req_sid(req_sid), .req_len(req_len), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_status(input string tag, input logic [2:0] code);
        logic [31:0] s;
        reg_read(A_ST, s);
        chk(tag, s, {28'd0, code, exp_err});
    endtask

    task automatic chk_req(input string tag, input logic [56:0] exp);
        chk(tag, {req_valid, req_class, req_write, req_sid, req_len, req_addr, req_wdata},
            {1'b1, exp});
    endtask

    function automatic logic [31:0] mask_len(input logic [31:0] d, input int len);
        return d & ~(32'hFFFF_FFFF << (8 * (len + 1)));
    endfunction

    task automatic do_reset();
        logic [31:0] v;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; exp_err = 1'b0;
        chk_status("R11 status after reset", 3'd0);
        reg_read(A_WD, v); chk("R11 wdata cleared", v, 0);
        reg_read(A_RD, v); chk("R11 rdata cleared", v, 0);
        chk("R11 req_valid low", req_valid, 0);
    endtask

    initial begin
        logic [31:0] v, rd_prev;
        do_reset();

        // response and valid-clear in idle are ignored
        @(negedge clk); rsp_valid = 1'b1; rsp_data = 32'hDEAD_BEEF;
        @(negedge clk); rsp_valid = 1'b0;
        reg_read(A_RD, v); chk("R12 rsp in idle ignored", v, 0);
        chk_status("R12 state after idle rsp", 3'd0);
        reg_write(A_CLR, 32'h1);
        chk_status("R8 clear in idle ignored", 3'd0);

        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 2; w++) begin
                for (int l = 0; l < 4; l++) begin
                    logic [3:0]  sid;
                    logic [15:0] ad;
                    logic [31:0] wd, cmdw, rsp;
                    logic [56:0] expr;
                    sid  = 4'((c * 8 + w * 4 + l) ^ 4'hA);
                    ad   = 16'hA000 + 16'(c * 256 + w * 16 + l);
                    wd   = 32'h1122_3344 ^ {8'(c), 8'(w), 8'(l), 8'h5A};
                    rsp  = 32'hC3A5_96E1 + 32'(c * 977 + w * 31 + l * 7);
                    cmdw = {2'(c), 1'(w), 1'b0, sid, 6'd0, 2'(l), ad};
                    reg_write(A_WD, wd);
                    reg_read(A_WD, v); chk("R10 wdata load in idle", v, wd);
                    reg_write(A_CMD, cmdw);
                    if (c == 2) begin
                        exp_err = 1'b1;
                        chk_status("R2 reserved class rejected", 3'd0);
                        chk("R2 no request raised", req_valid, 0);
                        continue;
                    end
                    expr = {2'(c), 1'(w), sid, 2'(l), ad, wd};
                    chk_status("R3 code 1 after command", 3'd1);
                    chk_req("R1 request fields", expr);
                    chk("R5 req_wdata is wdata reg", req_wdata, wd);
                    repeat (2) @(negedge clk);
                    chk_req("R4 request held while stalled", expr);
                    if (l == 1) begin
                        reg_write(A_CMD, ~cmdw);
                        exp_err = 1'b1;
                        chk_req("R9 busy command ignored", expr);
                        chk_status("R9 error bit set", 3'd1);
                    end
                    if (l == 2) begin
                        reg_write(A_WD, ~wd);
                        reg_read(A_WD, v); chk("R10 wdata write while busy", v, wd);
                        chk("R10 req_wdata unchanged", req_wdata, wd);
                    end
                    @(negedge clk); req_ready = 1'b1;
                    @(negedge clk); req_ready = 1'b0;
                    chk("R4 valid drops after handshake", req_valid, 0);
                    if (w == 1) begin
                        chk_status("R5 write back to idle", 3'd0);
                        continue;
                    end
                    chk_status("R6 code 2 awaiting response", 3'd2);
                    reg_write(A_CLR, 32'h1);
                    chk_status("R8 clear in code 2 ignored", 3'd2);
                    @(negedge clk); rsp_valid = 1'b1; rsp_data = rsp;
                    @(negedge clk); rsp_valid = 1'b0;
                    chk_status("R6 code 6 after response", 3'd6);
                    reg_read(A_RD, rd_prev);
                    chk("R6 masked read data", rd_prev, mask_len(rsp, l));
                    @(negedge clk); rsp_valid = 1'b1; rsp_data = ~rsp;
                    @(negedge clk); rsp_valid = 1'b0;
                    reg_read(A_RD, v); chk("R12 rsp in code 6 ignored", v, rd_prev);
                    reg_write(A_CLR, 32'hFFFF_FFFE);
                    chk_status("R8 clear with bit0 low ignored", 3'd6);
                    repeat (3) @(negedge clk);
                    chk_status("R7 hold persists", 3'd6);
                    reg_read(A_RD, v); chk("R7 rdata stable in hold", v, rd_prev);
                    reg_write(A_CLR, 32'h1);
                    chk_status("R7 clear returns to idle", 3'd0);
                end
            end
        end

        chk("R9 error sticky at end", exp_err, 1);
        chk_status("R9 status shows sticky error", 3'd0);
        do_reset();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule